// File: doc/BRIEF.md
# Per-lane pattern case matcher

This block is a purely combinational SIMD selector. It takes a 64-bit packed vector and a 2-bit layout code. The layout code splits the vector into four 16-bit lanes, two 32-bit lanes or one 64-bit lane. The same fixed case table is applied to every lane on its own. A lane that equals one of two exact constants gets a fixed "hit" constant in the same lane of the result. So does a lane that fits a wildcard bit pattern. Every other lane gets a fixed "miss" constant.

The case table is built into the block and cannot be changed at run time. It has three entries:
- the exact value 3;
- the exact value 10;
- a wildcard entry that needs bits [2:0] = 101, ignores bits 3 and 4, and needs every lane bit from bit 5 up to be zero.

The layout code uses the same encoding as a neighbouring lane-partitioned adder, so both blocks can be driven from one control field. Code 3 is a spare value and acts as the single-lane layout.

Top module: `lane_case_top`

## Requirements
- R1: With layout code 0, the vector holds four 16-bit lanes. Lane k is bits [16k+15:16k], and each lane's result goes to the same bit range of the output.
- R2: With layout code 1, the vector holds two 32-bit lanes (bits [31:0] and [63:32]). With layout code 2, the whole 64-bit vector is one lane.
- R3: A lane whose value is exactly 3 or exactly 10 gives the result 23 in that lane.
- R4: A lane with bits [2:0] = 101, any values in bits 3 and 4, and all bits above bit 4 zero gives the result 23. Within 16 or more bits, that means the values 5, 13, 21 and 29.
- R5: Any other lane value gives the result 45. This includes a lane whose low five bits would match an entry but which has a nonzero bit above bit 4.
- R6: Each lane's result is its constant zero-extended to the lane width, so bits 6 and up of every output lane are zero.
- R7: Lanes are independent. Changing one lane's input never changes another lane's output.
- R8: Layout code 3 gives exactly the same output as layout code 2 for any vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| layout_code | input | 2 | Lane layout: 0 = 4x16, 1 = 2x32, 2 or 3 = 1x64 |
| vec_in | input | 64 | Packed input lanes |
| vec_out | output | 64 | Packed per-lane result (23 on a match, 45 otherwise) |

## Verification
The assertions assume that both inputs are at known, settled values whenever they are evaluated. In other words, they assume the vector and the layout code change together and carry no X or Z. The bench meets this by driving both inputs at once on the falling clock edge and checking the output one nanosecond later.

The random stimulus keeps each lane within its layout's width. It biases many lanes toward the small case values and toward values just outside the case table, so the checks on the wildcard entry and on the high bits are actually triggered.

// File: rtl/lane_case_pkg.sv
// Package: shared types and constants of the per-lane case matcher.
// Holds the layout code encoding, the case table and the two result
// constants. The layout encoding must stay in step with the neighbouring
// partitioned adder.
package lane_case_pkg;

    localparam int PAT_W = 5;   // bits covered by a case-table entry
    localparam int RES_W = 6;   // bits needed by the result constants
    localparam int N_PAT = 3;   // number of case-table entries

    typedef enum logic [1:0] {
        LAYOUT_4X16   = 2'd0,
        LAYOUT_2X32   = 2'd1,
        LAYOUT_1X64   = 2'd2,
        LAYOUT_SPARE  = 2'd3
    } layout_e;

    // One case-table entry: the lane matches if (lane ^ value) & care is 0.
    typedef struct packed {
        logic [PAT_W-1:0] value;
        logic [PAT_W-1:0] care;
    } pattern_t;

    // Entry 0: exact 3, entry 1: exact 10, entry 2: xx101.
    localparam pattern_t [N_PAT-1:0] CASE_TABLE = {
        pattern_t'{value: 5'b00101, care: 5'b00111},
        pattern_t'{value: 5'd10,    care: 5'b11111},
        pattern_t'{value: 5'd3,     care: 5'b11111}
    };

    localparam logic [RES_W-1:0] HIT_CODE  = 6'd23;
    localparam logic [RES_W-1:0] MISS_CODE = 6'd45;

endpackage

// File: rtl/layout_decode.sv
// Module: layout_decode
// Turns the 2-bit layout code into a one-hot lane-width select
// (bit 0 = 16-bit lanes, bit 1 = 32-bit lanes, bit 2 = one 64-bit lane).
// Assumes the encoding from lane_case_pkg. The spare code selects the
// single-lane layout.
module layout_decode
    import lane_case_pkg::*;
(
    input  logic [1:0] layout_code,
    output logic [2:0] width_sel
);

    // Map each code to one lane-width select.
    always_comb begin
        unique case (layout_e'(layout_code))
            LAYOUT_4X16:  width_sel = 3'b001;
            LAYOUT_2X32:  width_sel = 3'b010;
            LAYOUT_1X64:  width_sel = 3'b100;
            LAYOUT_SPARE: width_sel = 3'b100;
            default:      width_sel = 3'b100;
        endcase
    end

endmodule

// File: rtl/lane_case.sv
// Module: lane_case
// Checks one lane against the fixed case table and gives the
// zero-extended hit or miss constant. Assumes LANE_W is larger than
// PAT_W. Every lane bit above the table's pattern width must be zero
// for any entry to match.
module lane_case
    import lane_case_pkg::*;
#(
    parameter int LANE_W = 16
) (
    input  logic [LANE_W-1:0] lane_in,
    output logic [LANE_W-1:0] lane_out
);

    localparam int HIGH_W = LANE_W - PAT_W;

    logic low_hit;
    logic high_clear;

    // Check whether the low bits fit any table entry under its care mask.
    always_comb begin
        low_hit = 1'b0;
        for (int p = 0; p < N_PAT; p++) begin
            if (((lane_in[PAT_W-1:0] ^ CASE_TABLE[p].value) & CASE_TABLE[p].care) == '0)
                low_hit = 1'b1;
        end
    end

    // Require every bit above the pattern width to be zero.
    always_comb high_clear = (lane_in[LANE_W-1:PAT_W] == {HIGH_W{1'b0}});

    // Pick the result constant, zero-extended to the lane width.
    always_comb lane_out = (low_hit && high_clear) ? LANE_W'(HIT_CODE) : LANE_W'(MISS_CODE);

endmodule

// File: rtl/lane_bank.sv
// Module: lane_bank
// Splits a packed vector into DATA_W/LANE_W lanes of the same width and
// runs one lane_case per lane. Assumes LANE_W divides DATA_W exactly.
module lane_bank #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 16
) (
    input  logic [DATA_W-1:0] vec_in,
    output logic [DATA_W-1:0] vec_out
);

    localparam int N_LANES = DATA_W / LANE_W;

    // One independent matcher per lane position.
    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
        lane_case #(.LANE_W(LANE_W)) u_lane (
            .lane_in  (vec_in [k*LANE_W +: LANE_W]),
            .lane_out (vec_out[k*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/lane_case_top.sv
// Module: lane_case_top
// Per-lane case matcher. Three banks of matchers (NARROW_W, 2*NARROW_W
// and 4*NARROW_W wide lanes) all see the input vector. The layout code
// picks which bank drives the output. Assumes DATA_W == 4*NARROW_W.
// Purely combinational.
module lane_case_top #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 16
) (
    input  logic [1:0]        layout_code,
    input  logic [DATA_W-1:0] vec_in,
    output logic [DATA_W-1:0] vec_out
);

    localparam int N_LAYOUTS = 3;

    logic [2:0]        width_sel;
    logic [DATA_W-1:0] bank_out [N_LAYOUTS];

    layout_decode u_decode (
        .layout_code (layout_code),
        .width_sel   (width_sel)
    );

    // One bank per lane width: NARROW_W, 2*NARROW_W, 4*NARROW_W.
    for (genvar g = 0; g < N_LAYOUTS; g++) begin : g_bank
        lane_bank #(.DATA_W(DATA_W), .LANE_W(NARROW_W << g)) u_bank (
            .vec_in  (vec_in),
            .vec_out (bank_out[g])
        );
    end

    // Forward the result of the bank the layout selects.
    always_comb begin
        vec_out = '0;
        for (int g = 0; g < N_LAYOUTS; g++) begin
            if (width_sel[g])
                vec_out = bank_out[g];
        end
    end

endmodule

// File: rtl/lane_case_chk.sv
// Module: lane_case_chk
// Assertion checker for lane_case_top, attached by bind below. Relates
// the input vector and layout code to the output lanes. Assumes the
// inputs are settled, known values whenever it is evaluated.
module lane_case_chk
    import lane_case_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 16
) (
    input logic [1:0]        layout_code,
    input logic [DATA_W-1:0] vec_in,
    input logic [DATA_W-1:0] vec_out
);

    localparam int MID_W = 2 * NARROW_W;
    localparam int N_NARROW = DATA_W / NARROW_W;

    // Per-lane checks in the four-lane layout (R1).
    for (genvar k = 0; k < N_NARROW; k++) begin : g_narrow
        logic [NARROW_W-1:0] li;
        logic [NARROW_W-1:0] lo;
        assign li = vec_in [k*NARROW_W +: NARROW_W];
        assign lo = vec_out[k*NARROW_W +: NARROW_W];

        // Check each narrow lane against the case rules.
        always_comb begin
            if (layout_code == 2'd0) begin
                p_lane_const_r6: assert (lo == NARROW_W'(23) || lo == NARROW_W'(45))
                    else $error("lane %0d result %0d is not a case constant", k, lo);
                if (li == NARROW_W'(3) || li == NARROW_W'(10))
                    p_exact_hit_r3: assert (lo == NARROW_W'(23))
                        else $error("lane %0d exact value missed", k);
                if (li[NARROW_W-1:PAT_W] == '0 && li[2:0] == 3'b101)
                    p_wild_hit_r4: assert (lo == NARROW_W'(23))
                        else $error("lane %0d wildcard value missed", k);
                if (li[NARROW_W-1:PAT_W] != '0)
                    p_high_miss_r5: assert (lo == NARROW_W'(45))
                        else $error("lane %0d with high bits matched", k);
            end
        end
    end

    // Check the upper bits of the wider layouts stay zero.
    always_comb begin
        if (layout_code == 2'd1) begin
            p_mid_zero_r2: assert (vec_out[MID_W-1:RES_W] == '0 && vec_out[DATA_W-1:MID_W+RES_W] == '0)
                else $error("two-lane result has stray upper bits");
        end
        if (layout_code[1]) begin
            p_wide_zero_r2: assert (vec_out[DATA_W-1:RES_W] == '0)
                else $error("single-lane result has stray upper bits");
        end
        if (layout_code == 2'd3 && vec_in == DATA_W'(3)) begin
            p_spare_hit_r8: assert (vec_out == DATA_W'(23))
                else $error("spare code did not act as the single lane");
        end
    end

endmodule

bind lane_case_top lane_case_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
    .layout_code (layout_code),
    .vec_in      (vec_in),
    .vec_out     (vec_out)
);

// File: tb/lane_case_top_test.sv
// Bench for lane_case_top: directed corner cases plus seeded random
// vectors, compared against a model written from the requirements.
module lane_case_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  layout_code = 2'd0;
    logic [63:0] vec_in = '0;
    logic [63:0] vec_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    lane_case_top uut (
        .layout_code (layout_code),
        .vec_in      (vec_in),
        .vec_out     (vec_out)
    );

    // Result of one lane from the case rules (R3, R4, R5).
    function automatic logic [63:0] lane_model(logic [63:0] v);
        if (v == 64'd3 || v == 64'd10) return 64'd23;
        if ((v >> 5) == 0 && v[2:0] == 3'b101) return 64'd23;
        return 64'd45;
    endfunction

    function automatic int width_of(logic [1:0] code);
        return (code == 2'd0) ? 16 : (code == 2'd1) ? 32 : 64;
    endfunction

    function automatic logic [63:0] mask_of(int w);
        return (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    endfunction

    // Whole-vector model (R1, R2, R6, R8).
    function automatic logic [63:0] vec_model(logic [1:0] code, logic [63:0] v);
        int w = width_of(code);
        logic [63:0] m = mask_of(w);
        logic [63:0] r = '0;
        for (int k = 0; k < 64 / w; k++)
            r |= lane_model((v >> (k * w)) & m) << (k * w);
        return r;
    endfunction

    // Random lane value, often near the case values.
    function automatic logic [63:0] gen_lane(int w);
        int sel = $urandom % 6;
        logic [63:0] v;
        case (sel)
            0: v = 64'($urandom % 32);
            1: begin
                int pick = $urandom % 6;
                v = (pick == 0) ? 64'd3 : (pick == 1) ? 64'd10 : 64'(5 + 8 * (pick - 2));
            end
            2: v = 64'($urandom % 32) | (64'd1 << ($urandom % w));
            default: v = {32'($urandom), 32'($urandom)};
        endcase
        return v & mask_of(w);
    endfunction

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h (code %0d vec %h)", req, got, exp, layout_code, vec_in);
        end
    endtask

    // Drive on the falling edge, sample 1 ns later.
    task automatic apply(logic [1:0] code, logic [63:0] v);
        @(negedge clk);
        layout_code = code;
        vec_in = v;
        #1;
    endtask

    task automatic run_one(string req, logic [1:0] code, logic [63:0] v);
        apply(code, v);
        check(req, vec_out, vec_model(code, v));
    endtask

    initial begin
        logic [63:0] prev;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle state: all-zero input misses in every lane (R5, R1).
        apply(2'd0, 64'd0);
        check("R5 idle four-lane", vec_out, {4{16'd45}});

        // Exact values in separate lanes (R3, R1).
        apply(2'd0, {16'd10, 16'd7, 16'd3, 16'd0});
        check("R3 exact four-lane", vec_out, {16'd23, 16'd45, 16'd23, 16'd45});

        // Wildcard values 5, 13, 21, 29 (R4).
        apply(2'd0, {16'd29, 16'd21, 16'd13, 16'd5});
        check("R4 wildcard all hit", vec_out, {4{16'd23}});

        // High bits break a match: 35 = 3 | 32, 0x8005 (R5).
        apply(2'd0, {16'h8005, 16'd35, 16'd45, 16'd31});
        check("R5 high bits miss", vec_out, {4{16'd45}});

        // Two-lane layout (R2, R6).
        apply(2'd1, {32'd13, 32'h0001_0003});
        check("R2 two-lane", vec_out, {32'd23, 32'd45});

        // A value that is a hit at 16 bits is a miss in one 64-bit lane (R2).
        apply(2'd2, 64'h0000_0003_0000_0003);
        check("R2 single lane high word", vec_out, 64'd45);
        apply(2'd0, 64'h0000_0003_0000_0003);
        check("R1 same vector four-lane", vec_out, {16'd45, 16'd23, 16'd45, 16'd23});

        // Spare code matches the single-lane layout (R8).
        apply(2'd3, 64'd21);
        check("R8 spare code hit", vec_out, 64'd23);
        apply(2'd3, 64'h8000_0000_0000_000A);
        check("R8 spare code miss", vec_out, 64'd45);

        // Zero-extension of results in each layout (R6).
        apply(2'd2, 64'd10);
        check("R6 wide zero-extended", vec_out, 64'd23);

        // Independence: change one lane only (R7).
        apply(2'd0, {16'd3, 16'd35, 16'd13, 16'd7});
        prev = vec_out;
        check("R7 before change", vec_out, {16'd23, 16'd45, 16'd23, 16'd45});
        apply(2'd0, {16'd3, 16'd10, 16'd13, 16'd7});
        check("R7 lane 2 changed", vec_out[47:32], 64'(16'd23));
        check("R7 other lanes held", {vec_out[63:48], vec_out[31:0]}, 64'({prev[63:48], prev[31:0]}));

        // Random mix across all codes (R1, R2, R3, R4, R5, R6, R8).
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] code = 2'($urandom % 4);
            int w = width_of(code);
            logic [63:0] v = '0;
            for (int k = 0; k < 64 / w; k++)
                v |= gen_lane(w) << (k * w);
            run_one("R1/R2/R3/R4/R5 random", code, v);
            if (code >= 2'd2) begin
                apply(code ^ 2'd1, v);
                check("R8 code 2 vs 3", vec_out, vec_model(2'd2, v));
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule